// File: doc/BRIEF.md
# MSI Doorbell Write Decoder

This block sits between a 32-bit register bus and a bank of interrupt files. The address space it decodes is cut into equal pages, one page per interrupt file. A write of an interrupt identity to the first word of a page is a message-signalled interrupt. The block checks the access and, when the access is good, emits a single-cycle set-pending strobe. The strobe carries the page index and the identity as separate fields. The pending bits themselves are held by the interrupt files downstream.

Reads always return zero, and the bus never sees an error response. The block flags a faulty access with a one-cycle pulse on a separate output, which a logging unit may use. An access is faulty if its address is not word aligned, if it falls past the last page, or if it is not a full-word access. A legal write to any other place in a page is accepted without a flag and has no effect. This includes the second word of a page, which is kept for a big-endian doorbell. A doorbell write whose identity is out of range is also dropped without a flag.

Top module: `msi_doorbell_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `set_valid` and `fault_pulse` are 0.
- R2: A doorbell write raises `set_valid` for the cycle after the access. A doorbell write has `bus_valid`=1, `bus_write`=1, `bus_be`=4'b1111, an address below NUM_PAGES*2^PAGE_SHIFT and bits [PAGE_SHIFT-1:0] zero, and data in 1..NUM_IDS-1. In that cycle `set_page` = address bits [PAGE_SHIFT+PG_W-1:PAGE_SHIFT] and `set_id` = data bits [ID_W-1:0].
- R3: Each accepted access gives exactly one strobe cycle. If the bus is idle in the following cycle, `set_valid` is 0 in the cycle after that. Two doorbell writes in consecutive cycles give two consecutive strobes, each with its own page and identity.
- R4: A doorbell write whose data is 0 or at least NUM_IDS produces neither a strobe nor a fault pulse.
- R5: An access (read or write) with `bus_addr[1:0]` != 0 raises `fault_pulse` for the following cycle and produces no strobe.
- R6: An access with an address at or above NUM_PAGES*2^PAGE_SHIFT raises `fault_pulse` for the following cycle and produces no strobe.
- R7: An access whose `bus_be` is not 4'b1111 raises `fault_pulse` for the following cycle and produces no strobe.
- R8: A legal write to a nonzero in-page offset, including the big-endian word at offset 4, produces neither a strobe nor a fault pulse.
- R9: `bus_rdata` is zero at all times. A legal read produces no strobe and no fault pulse.
- R10: `set_valid` and `fault_pulse` are never high in the same cycle, and each fault pulse lasts one cycle per faulty access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address relative to the block base |
| bus_be | input | 4 | Byte enables; only 4'b1111 is legal |
| bus_wdata | input | 32 | Write data (the identity for a doorbell) |
| bus_rdata | output | 32 | Read data, always zero |
| set_valid | output | 1 | One-cycle set-pending strobe |
| set_page | output | PG_W | Interrupt file index of the strobe |
| set_id | output | ID_W | Identity to mark pending |
| fault_pulse | output | 1 | One-cycle flag for a misaligned, out-of-range or partial access |

## Verification
The assertions assume that each cycle with `bus_valid` high is one complete access and that the bus is held low through reset. They also assume the access fields are stable across the sampling edge, so that `$past` of the address and data names the access that caused each strobe or flag. The stimulus drives every field on the falling edge and drops `bus_valid` between accesses, except in the directed back-to-back case. The random mix spreads accesses over all pages plus one page beyond the last, over offsets 0, 4, other aligned words and misaligned bytes, over partial byte enables, and over identities around both ends of the legal range.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;

   // outcome of one bus cycle
   typedef enum logic [1:0] {
      DEC_IDLE   = 2'd0,
      DEC_RING   = 2'd1,
      DEC_IGNORE = 2'd2,
      DEC_FAULT  = 2'd3
   } dec_kind_e;

   localparam int unsigned BUS_W     = 32;
   localparam int unsigned BE_W      = BUS_W / 8;
   localparam logic [BE_W-1:0] FULL_BE = '1;

endpackage

// File: rtl/msi_dbl_addr_check.sv
module msi_dbl_addr_check #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_PAGES  = 4,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PG_W       = 2
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic [msi_dbl_pkg::BE_W-1:0]    be,
   output logic                            aligned_ok,
   output logic                            range_ok,
   output logic                            size_ok,
   output logic                            at_bell,
   output logic [PG_W-1:0]                 page
);
   import msi_dbl_pkg::*;

   localparam int unsigned LOG_PAGES = $clog2(NUM_PAGES);
   localparam bit          PAGES_P2  = (NUM_PAGES == (1 << LOG_PAGES));
   localparam logic [ADDR_W:0] SPAN  = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

   initial begin
      assert (PAGE_SHIFT >= 3 && PAGE_SHIFT < ADDR_W)
         else $fatal(1, "PAGE_SHIFT out of range");
      assert (ADDR_W > PAGE_SHIFT + LOG_PAGES)
         else $fatal(1, "ADDR_W too small for the page span");
      assert (PG_W >= 1 && (1 << PG_W) >= NUM_PAGES)
         else $fatal(1, "PG_W cannot index every page");
   end

   assign aligned_ok = (addr[1:0] == 2'b00);
   assign size_ok    = (be == FULL_BE);
   assign at_bell    = (addr[PAGE_SHIFT-1:0] == '0);
   assign page       = addr[PAGE_SHIFT +: PG_W];

   generate
      if (PAGES_P2) begin : g_range_p2
         // power-of-two span: upper address bits must be clear
         assign range_ok = ((addr >> (PAGE_SHIFT + LOG_PAGES)) == '0);
      end else begin : g_range_cmp
         assign range_ok = ({1'b0, addr} < SPAN);
      end
   endgenerate

endmodule

// File: rtl/msi_dbl_id_check.sv
module msi_dbl_id_check #(
   parameter int unsigned NUM_IDS = 64,
   parameter int unsigned ID_W    = 6
) (
   input  logic [msi_dbl_pkg::BUS_W-1:0] wdata,
   output logic                          id_ok,
   output logic [ID_W-1:0]               id
);
   import msi_dbl_pkg::*;

   localparam bit IDS_P2 = (NUM_IDS == (1 << $clog2(NUM_IDS)));

   initial begin
      assert (NUM_IDS >= 2 && NUM_IDS <= 2048)
         else $fatal(1, "NUM_IDS out of range");
      assert (ID_W >= 1 && ID_W < BUS_W && (1 << ID_W) >= NUM_IDS)
         else $fatal(1, "ID_W cannot hold every identity");
   end

   assign id = wdata[ID_W-1:0];

   generate
      if (IDS_P2) begin : g_id_p2
         // all identity bits inside the field, field not zero
         assign id_ok = (wdata[BUS_W-1:ID_W] == '0) && (wdata[ID_W-1:0] != '0);
      end else begin : g_id_cmp
         assign id_ok = (wdata != '0) && (wdata < BUS_W'(NUM_IDS));
      end
   endgenerate

endmodule

// File: rtl/msi_dbl_out_stage.sv
module msi_dbl_out_stage #(
   parameter int unsigned PG_W = 2,
   parameter int unsigned ID_W = 6
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  msi_dbl_pkg::dec_kind_e     kind,
   input  logic [PG_W-1:0]            page_in,
   input  logic [ID_W-1:0]            id_in,
   output logic                       set_valid,
   output logic [PG_W-1:0]            set_page,
   output logic [ID_W-1:0]            set_id,
   output logic                       fault_pulse
);
   import msi_dbl_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         set_valid   <= 1'b0;
         fault_pulse <= 1'b0;
         set_page    <= '0;
         set_id      <= '0;
      end else begin
         set_valid   <= (kind == DEC_RING);
         fault_pulse <= (kind == DEC_FAULT);
         if (kind == DEC_RING) begin
            set_page <= page_in;
            set_id   <= id_in;
         end
      end
   end

   // R10
   strobe_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_valid && fault_pulse));

   // R3
   strobe_needs_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_valid |-> $past(kind) == DEC_RING);

endmodule

// File: rtl/msi_doorbell_decoder.sv
module msi_doorbell_decoder #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned NUM_PAGES  = 4,
   parameter int unsigned NUM_IDS    = 64,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
   parameter int unsigned ID_W       = $clog2(NUM_IDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [3:0]            bus_be,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   output logic                  set_valid,
   output logic [PG_W-1:0]       set_page,
   output logic [ID_W-1:0]       set_id,
   output logic                  fault_pulse
);
   import msi_dbl_pkg::*;

   localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NUM_PAGES) << PAGE_SHIFT;

   logic            aligned_ok, range_ok, size_ok, at_bell, id_ok;
   logic [PG_W-1:0] page;
   logic [ID_W-1:0] id;
   dec_kind_e       kind;

   msi_dbl_addr_check #(
      .ADDR_W(ADDR_W), .NUM_PAGES(NUM_PAGES),
      .PAGE_SHIFT(PAGE_SHIFT), .PG_W(PG_W)
   ) u_addr (
      .addr(bus_addr), .be(bus_be),
      .aligned_ok(aligned_ok), .range_ok(range_ok), .size_ok(size_ok),
      .at_bell(at_bell), .page(page)
   );

   msi_dbl_id_check #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_id (
      .wdata(bus_wdata), .id_ok(id_ok), .id(id)
   );

   always_comb begin
      kind = DEC_IDLE;
      if (bus_valid) begin
         if (!(aligned_ok && range_ok && size_ok))
            kind = DEC_FAULT;
         else if (bus_write && at_bell && id_ok)
            kind = DEC_RING;
         else
            kind = DEC_IGNORE;
      end
   end

   msi_dbl_out_stage #(.PG_W(PG_W), .ID_W(ID_W)) u_out (
      .clk(clk), .rst_n(rst_n), .kind(kind),
      .page_in(page), .id_in(id),
      .set_valid(set_valid), .set_page(set_page), .set_id(set_id),
      .fault_pulse(fault_pulse)
   );

   assign bus_rdata = '0;

   // R5
   misalign_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[1:0] != 2'b00) |=> (fault_pulse && !set_valid));

   // R6
   range_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && {1'b0, bus_addr} >= SPAN) |=> (fault_pulse && !set_valid));

   // R7
   partial_be_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_be != 4'b1111) |=> fault_pulse);

   // R4
   zero_id_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_wdata == '0) |=> !set_valid);

   // R8
   off_bell_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr[PAGE_SHIFT-1:0] != '0) |=> !set_valid);

   // R9
   read_no_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> !set_valid);

   // R2
   ring_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_valid |-> (set_page == $past(bus_addr[PAGE_SHIFT +: PG_W])
                     && set_id == $past(bus_wdata[ID_W-1:0])));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> (!set_valid && !fault_pulse));

endmodule

// File: tb/msi_doorbell_decoder_test.sv
module msi_doorbell_decoder_test;

   localparam int unsigned NP = 4;
   localparam int unsigned NI = 64;
   localparam int unsigned PS = 12;
   localparam int unsigned PGW = 2;
   localparam int unsigned IDW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic        set_valid, fault_pulse;
   logic [PGW-1:0] set_page;
   logic [IDW-1:0] set_id;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   msi_doorbell_decoder uut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .set_valid(set_valid), .set_page(set_page),
      .set_id(set_id), .fault_pulse(fault_pulse)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // expected outcome from the requirements
   function automatic bit exp_fault(input logic [31:0] a, input logic [3:0] be);
      return (a[1:0] != 2'b00) || (64'(a) >= 64'(NP) * 64'(1 << PS)) || (be != 4'b1111);
   endfunction

   function automatic bit exp_ring(input bit wr, input logic [31:0] a,
                                   input logic [3:0] be, input logic [31:0] d);
      return wr && !exp_fault(a, be) && (a[PS-1:0] == '0) && (d != 0) && (d < NI);
   endfunction

   task automatic check_out(input bit er, input bit ef, input logic [31:0] a,
                            input logic [31:0] d, input string tag);
      chk(set_valid == er, {tag, " strobe"}, 32'(set_valid), 32'(er));
      chk(fault_pulse == ef, {tag, " fault"}, 32'(fault_pulse), 32'(ef));
      if (er) begin
         chk(set_page == a[PS +: PGW], "R2 page", 32'(set_page), 32'(a[PS +: PGW]));
         chk(set_id == d[IDW-1:0], "R2 id", 32'(set_id), 32'(d[IDW-1:0]));
      end
   endtask

   // one access, then the result cycle, then one idle cycle
   task automatic access(input bit wr, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] d, input string tag);
      bit er, ef;
      er = exp_ring(wr, a, be, d);
      ef = exp_fault(a, be);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
      #1 chk(bus_rdata == 0, "R9 rdata", bus_rdata, 0);
      @(negedge clk);
      bus_valid = 1'b0;
      check_out(er, ef, a, d, tag);
      @(negedge clk);
      // R3 R10: one cycle only
      chk(!set_valid && !fault_pulse, "R3 R10 single cycle",
          {30'd0, set_valid, fault_pulse}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(!set_valid && !fault_pulse, "R1 in reset", {30'd0, set_valid, fault_pulse}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!set_valid && !fault_pulse, "R1 after reset", {30'd0, set_valid, fault_pulse}, 0);

      // directed corners
      access(1, 32'h0000_0000, 4'hF, 32'd5, "R2 page0");
      access(1, 32'h0000_3000, 4'hF, 32'd63, "R2 last page top id");
      access(1, 32'h0000_1000, 4'hF, 32'd1, "R2 lowest id");
      access(1, 32'h0000_1000, 4'hF, 32'd0, "R4 zero id");
      access(1, 32'h0000_2000, 4'hF, 32'd64, "R4 id too big");
      access(1, 32'h0000_2000, 4'hF, 32'h8000_0003, "R4 huge id");
      access(1, 32'h0000_1002, 4'hF, 32'd7, "R5 misaligned write");
      access(0, 32'h0000_0001, 4'hF, 32'd0, "R5 misaligned read");
      access(1, 32'h0000_4000, 4'hF, 32'd9, "R6 first page past end");
      access(1, 32'hFFFF_FFF0, 4'hF, 32'd9, "R6 top of address space");
      access(1, 32'h0000_0000, 4'h3, 32'd9, "R7 half word");
      access(1, 32'h0000_0004, 4'hF, 32'd9, "R8 big-endian word");
      access(1, 32'h0000_2FFC, 4'hF, 32'd9, "R8 last word of page");
      access(0, 32'h0000_0000, 4'hF, 32'd9, "R9 legal read");

      // R3 back-to-back doorbells
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_be = 4'hF; bus_addr = 32'h1000; bus_wdata = 32'd11;
      @(negedge clk);
      bus_addr = 32'h3000; bus_wdata = 32'd22;
      check_out(1, 0, 32'h1000, 32'd11, "R3 first of pair");
      @(negedge clk);
      bus_valid = 0;
      check_out(1, 0, 32'h3000, 32'd22, "R3 second of pair");
      @(negedge clk);
      check_out(0, 0, 0, 0, "R3 after pair");

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a, d;
         logic [3:0]  be;
         bit          wr;
         int unsigned r;
         a = 32'($urandom_range(0, NP)) << PS;
         r = $urandom_range(0, 9);
         if (r == 6) a += 32'd4;
         else if (r == 7) a += {$urandom_range(0, (1 << (PS - 2)) - 1), 2'b00};
         else if (r == 8) a += 32'($urandom_range(1, 3));
         else if (r == 9) a += 32'd6;
         be = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
         d  = ($urandom_range(0, 15) == 0) ? $urandom() : 32'($urandom_range(0, NI + 2));
         wr = ($urandom_range(0, 99) < 85);
         access(wr, a, be, d, "R2 R4 R5 R6 R7 R8 random");
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule